// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block turns a logical address into a physical one in two dependent table reads. The logical address has three parts: a segment number, a page number inside that segment, and an in-page offset. The segment number selects a descriptor that names where the segment's page list starts in a shared frame table and how many pages the segment owns. The page number is then added to that start to pick a frame-table entry. That entry gives a frame number and a valid flag. The physical address is the frame number with the untouched offset placed below it.

Software fills the segment descriptors and the frame-table entries through two write ports. A requester offers an address when `req_ready` is high. The block then walks a small state machine: ST_IDLE, ST_SEG_LOOKUP, ST_PAGE_LOOKUP, ST_DONE. It leaves ST_IDLE for ST_SEG_LOOKUP when a request arrives. From ST_SEG_LOOKUP it goes to ST_PAGE_LOOKUP when the descriptor is usable, and straight to ST_DONE on a segment fault. ST_PAGE_LOOKUP always moves to ST_DONE, and ST_DONE always returns to ST_IDLE. A one-cycle `rsp_done` reports the outcome, and `rsp_fault` marks an addressing error.

Top module: `segpage_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, `rsp_fault` is 0 and `rsp_paddr` is 0. All segment descriptors and frame entries read as not valid.
- R2: The logical address splits as follows: bits [8:7] hold the segment number, bits [6:4] the page number and bits [3:0] the offset. A good result is `rsp_paddr` = {frame[3:0], offset[3:0]}.
- R3: The segment number indexes the descriptor table directly. The frame-table index is (descriptor base + page number) modulo 32.
- R4: A request to a segment whose descriptor is not valid ends with `rsp_done`=1 and `rsp_fault`=1 two cycles after the accepting edge, without passing through ST_PAGE_LOOKUP.
- R5: A page number greater than or equal to the segment's page count also faults two cycles after the accepting edge. A count of 0 therefore faults every page.
- R6: When the selected frame entry is not valid, the request faults three cycles after the accepting edge.
- R7: A request that passes all checks ends with `rsp_done`=1, `rsp_fault`=0 and the translated address, three cycles after the accepting edge.
- R8: A request is taken only while `req_ready` is 1 (ST_IDLE). `req_valid` raised while busy is ignored and does not change the result in progress.
- R9: `rsp_done` is high for exactly one cycle. `req_ready` is 1 in the cycle after it.
- R10: When `rsp_fault` is 1, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Write a segment descriptor |
| seg_wr_id | input | 2 | Descriptor being written |
| seg_wr_base | input | 5 | Frame-table start index of the segment |
| seg_wr_pages | input | 4 | Page count of the segment (0..8) |
| seg_wr_valid | input | 1 | Descriptor valid flag |
| pt_wr_en | input | 1 | Write a frame-table entry |
| pt_wr_idx | input | 5 | Frame-table entry being written |
| pt_wr_frame | input | 4 | Frame number |
| pt_wr_valid | input | 1 | Entry valid flag |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 9 | Logical address |
| req_ready | output | 1 | High in ST_IDLE |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Addressing error flag |
| rsp_paddr | output | 8 | Physical address |

## Verification
The bench builds the block with its default parameters: 2 segment bits, 3 page bits, 4 offset bits, 4 frame bits and a 32-entry frame table. With these sizes every descriptor and every frame entry can be loaded and reached. A base of 30 makes the index wrap past entry 31, and a page count of 8 allows the full page field. Each cycle, a behavioural reference model predicts `rsp_done`, `req_ready`, `rsp_fault` and `rsp_paddr` for hits, segment faults, page-count faults, invalid frame entries and requests that arrive while the block is busy.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_SEG_LOOKUP  = 2'd1,
        ST_PAGE_LOOKUP = 2'd2,
        ST_DONE        = 2'd3
    } xl_state_t;
endpackage

// File: rtl/segxl_segtab.sv
module segxl_segtab #(
    parameter int SEG_W    = 2,
    parameter int IDX_W    = 5,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_id,
    input  logic [IDX_W-1:0] wr_base,
    input  logic [CNT_W-1:0] wr_pages,
    input  logic             wr_valid,
    input  logic [SEG_W-1:0] rd_id,
    output logic [IDX_W-1:0] rd_base,
    output logic [CNT_W-1:0] rd_pages,
    output logic             rd_valid
);
    localparam int NSEG = 1 << SEG_W;

    logic [IDX_W-1:0] base_q  [NSEG];
    logic [CNT_W-1:0] pages_q [NSEG];
    logic [NSEG-1:0]  valid_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_desc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                pages_q[g] <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_id == SEG_W'(g)) begin
                base_q[g]  <= wr_base;
                pages_q[g] <= wr_pages;
                valid_q[g] <= wr_valid;
            end
        end
    end

    always_comb begin
        rd_base  = base_q[rd_id];
        rd_pages = pages_q[rd_id];
        rd_valid = valid_q[rd_id];
    end
endmodule

// File: rtl/segxl_frametab.sv
module segxl_frametab #(
    parameter int DEPTH   = 32,
    parameter int FRAME_W = 4,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid
);
    logic [FRAME_W-1:0] frame_q [DEPTH];
    logic [DEPTH-1:0]   valid_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[g] <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                frame_q[g] <= wr_frame;
                valid_q[g] <= wr_valid;
            end
        end
    end

    always_comb begin
        rd_frame = frame_q[rd_idx];
        rd_valid = valid_q[rd_idx];
    end
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate #(
    parameter int SEG_W    = 2,
    parameter int PAGE_W   = 3,
    parameter int OFS_W    = 4,
    parameter int FRAME_W  = 4,
    parameter int PT_DEPTH = 32,
    localparam int PT_IDX_W = $clog2(PT_DEPTH),
    localparam int CNT_W    = PAGE_W + 1,
    localparam int LA_W     = SEG_W + PAGE_W + OFS_W,
    localparam int PA_W     = FRAME_W + OFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seg_wr_en,
    input  logic [SEG_W-1:0]    seg_wr_id,
    input  logic [PT_IDX_W-1:0] seg_wr_base,
    input  logic [CNT_W-1:0]    seg_wr_pages,
    input  logic                seg_wr_valid,
    input  logic                pt_wr_en,
    input  logic [PT_IDX_W-1:0] pt_wr_idx,
    input  logic [FRAME_W-1:0]  pt_wr_frame,
    input  logic                pt_wr_valid,
    input  logic                req_valid,
    input  logic [LA_W-1:0]     req_laddr,
    output logic                req_ready,
    output logic                rsp_done,
    output logic                rsp_fault,
    output logic [PA_W-1:0]     rsp_paddr
);
    import segxl_pkg::*;

    xl_state_t state_q, state_d;

    logic [LA_W-1:0]     laddr_q;
    logic [PT_IDX_W-1:0] pt_idx_q;
    logic [PA_W-1:0]     paddr_q;
    logic                fault_q;

    logic [SEG_W-1:0]    cur_seg;
    logic [PAGE_W-1:0]   cur_page;
    logic [OFS_W-1:0]    cur_ofs;

    logic [PT_IDX_W-1:0] sd_base;
    logic [CNT_W-1:0]    sd_pages;
    logic                sd_valid;
    logic [FRAME_W-1:0]  fe_frame;
    logic                fe_valid;

    logic                seg_ok;
    logic [PT_IDX_W-1:0] pt_idx_d;

    assign cur_seg  = laddr_q[LA_W-1 -: SEG_W];
    assign cur_page = laddr_q[OFS_W +: PAGE_W];
    assign cur_ofs  = laddr_q[OFS_W-1:0];

    segxl_segtab #(
        .SEG_W (SEG_W),
        .IDX_W (PT_IDX_W),
        .CNT_W (CNT_W)
    ) u_segtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (seg_wr_en),
        .wr_id    (seg_wr_id),
        .wr_base  (seg_wr_base),
        .wr_pages (seg_wr_pages),
        .wr_valid (seg_wr_valid),
        .rd_id    (cur_seg),
        .rd_base  (sd_base),
        .rd_pages (sd_pages),
        .rd_valid (sd_valid)
    );

    segxl_frametab #(
        .DEPTH   (PT_DEPTH),
        .FRAME_W (FRAME_W)
    ) u_frametab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pt_wr_en),
        .wr_idx   (pt_wr_idx),
        .wr_frame (pt_wr_frame),
        .wr_valid (pt_wr_valid),
        .rd_idx   (pt_idx_q),
        .rd_frame (fe_frame),
        .rd_valid (fe_valid)
    );

    // Segment checks between the two lookups.
    assign seg_ok   = sd_valid && ({1'b0, cur_page} < sd_pages);
    assign pt_idx_d = sd_base + {{(PT_IDX_W-PAGE_W){1'b0}}, cur_page};

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            laddr_q  <= '0;
            pt_idx_q <= '0;
            paddr_q  <= '0;
            fault_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        laddr_q <= req_laddr;
                        fault_q <= 1'b0;
                        paddr_q <= '0;
                    end
                end
                ST_SEG_LOOKUP: begin
                    pt_idx_q <= pt_idx_d;
                    if (!seg_ok) begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                    end
                end
                ST_PAGE_LOOKUP: begin
                    if (fe_valid) begin
                        fault_q <= 1'b0;
                        paddr_q <= {fe_frame, cur_ofs};
                    end else begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid) state_d = ST_SEG_LOOKUP;
            ST_SEG_LOOKUP:  state_d = seg_ok ? ST_PAGE_LOOKUP : ST_DONE;
            ST_PAGE_LOOKUP: state_d = ST_DONE;
            ST_DONE:        state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_DONE);
        rsp_fault = fault_q;
        rsp_paddr = paddr_q;
    end

    // Assertions
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready);
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);
    a_r4_bad_seg_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEG_LOOKUP && !sd_valid) |=> (rsp_done && rsp_fault));
    a_r6_bad_frame_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE_LOOKUP && !fe_valid) |=> (rsp_done && rsp_fault));
    a_r10_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault) |-> (rsp_paddr == '0));
    a_r7_good_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_fault) |-> (rsp_paddr[OFS_W-1:0] == laddr_q[OFS_W-1:0]));
endmodule

// File: tb/segpage_xlate_tb_top.sv
module segpage_xlate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seg_wr_en = 1'b0;
    logic [1:0] seg_wr_id = '0;
    logic [4:0] seg_wr_base = '0;
    logic [3:0] seg_wr_pages = '0;
    logic       seg_wr_valid = 1'b0;
    logic       pt_wr_en = 1'b0;
    logic [4:0] pt_wr_idx = '0;
    logic [3:0] pt_wr_frame = '0;
    logic       pt_wr_valid = 1'b0;
    logic       req_valid = 1'b0;
    logic [8:0] req_laddr = '0;
    logic       req_ready, rsp_done, rsp_fault;
    logic [7:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference tables
    bit m_sv [4];
    int m_sb [4];
    int m_sc [4];
    bit m_fv [32];
    int m_ff [32];

    always #2 clk = ~clk;

    segpage_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_id(seg_wr_id), .seg_wr_base(seg_wr_base),
        .seg_wr_pages(seg_wr_pages), .seg_wr_valid(seg_wr_valid),
        .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx), .pt_wr_frame(pt_wr_frame),
        .pt_wr_valid(pt_wr_valid),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_seg(input int id, input int base, input int cnt, input bit v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_id = 2'(id); seg_wr_base = 5'(base);
        seg_wr_pages = 4'(cnt); seg_wr_valid = v;
        m_sv[id] = v; m_sb[id] = base; m_sc[id] = cnt;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic load_pte(input int idx, input int fr, input bit v);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_idx = 5'(idx); pt_wr_frame = 4'(fr); pt_wr_valid = v;
        m_ff[idx] = fr; m_fv[idx] = v;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    // Issue one request and compare every cycle against the model.
    task automatic run(input int la, input bit intrude, input string tag);
        int s, p, o, lat, idx;
        bit flt;
        int pa;
        s = (la >> 7) & 3; p = (la >> 4) & 7; o = la & 15;
        if (!m_sv[s] || p >= m_sc[s]) begin
            lat = 2; flt = 1'b1; pa = 0;
        end else begin
            lat = 3; idx = (m_sb[s] + p) % 32;
            flt = !m_fv[idx];
            pa = flt ? 0 : (m_ff[idx] * 16 + o);
        end
        @(negedge clk);
        chk(req_ready == 1'b1, {"R8 ready idle ", tag}, int'(req_ready), 1);
        req_valid = 1'b1; req_laddr = 9'(la);
        for (int c = 1; c <= lat + 1; c++) begin
            @(negedge clk);
            chk(rsp_done == (c == lat), {"R9 done timing ", tag}, int'(rsp_done), int'(c == lat));
            chk(req_ready == (c == lat + 1), {"R8 ready timing ", tag}, int'(req_ready), int'(c == lat + 1));
            if (c == lat) begin
                chk(rsp_fault == flt, {"R4 R5 R6 R7 fault ", tag}, int'(rsp_fault), int'(flt));
                chk(int'(rsp_paddr) == pa, {"R2 R3 R10 paddr ", tag}, int'(rsp_paddr), pa);
            end
            if (c == 1 && intrude) begin
                req_valid = 1'b1; req_laddr = 9'(la ^ 9'h1FF);
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_done == 1'b0, "R1 done", int'(rsp_done), 0);
        chk(rsp_fault == 1'b0, "R1 fault", int'(rsp_fault), 0);
        chk(rsp_paddr == 8'd0, "R1 paddr", int'(rsp_paddr), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin m_sv[i] = 0; m_sb[i] = 0; m_sc[i] = 0; end
        for (int i = 0; i < 32; i++) begin m_fv[i] = 0; m_ff[i] = 0; end
        // R1: tables empty after reset, so any request faults on the segment
        run(9'h0A5, 1'b0, "R1 empty tables");
        load_seg(0, 0, 4, 1'b1);
        load_seg(1, 8, 8, 1'b1);
        load_seg(2, 16, 8, 1'b0);
        load_seg(3, 30, 3, 1'b1);
        for (int i = 0; i < 32; i++) load_pte(i, (i * 7 + 3) % 16, (i % 5) != 4);
        run((0 << 7) | (1 << 4) | 5, 1'b0, "R7 seg0 page1");
        run((1 << 7) | (7 << 4) | 15, 1'b0, "R7 seg1 page7");
        run((1 << 7) | (1 << 4) | 2, 1'b0, "R6 invalid frame");
        run((2 << 7) | (0 << 4) | 9, 1'b0, "R4 invalid segment");
        run((0 << 7) | (4 << 4) | 1, 1'b0, "R5 page at count");
        run((3 << 7) | (2 << 4) | 6, 1'b0, "R3 index wrap");
        run((3 << 7) | (3 << 4) | 6, 1'b0, "R5 seg3 over count");
        run((0 << 7) | (2 << 4) | 12, 1'b1, "R8 busy request ignored");
        run((2 << 7) | (5 << 4) | 3, 1'b1, "R8 busy during fault");
        load_seg(0, 0, 0, 1'b1);
        run((0 << 7) | (0 << 4) | 7, 1'b0, "R5 zero count");
        for (int k = 0; k < 40; k++) run((k * 37 + 11) % 512, (k % 3) == 0, "R2 sweep");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule